// File: doc/BRIEF.md
# RTC Alarm Compare and Interrupt Status

This block holds the alarm-match and interrupt-status part of a real-time clock. It compares the current seconds, minutes and hours bytes against three alarm bytes. An alarm byte whose two most significant bits are both set acts as a wildcard for its field.

It also keeps the interrupt status byte. That byte collects three events: the periodic tick, the alarm match and the end of a time update. It carries a summary bit that is set when any collected event has its enable bit high. The summary bit drives the interrupt request pin. The host reads the status byte and pulses a read strobe, and this clears every flag.

Time counting, number-format conversion and host address decoding are left to neighbouring blocks. The block sees the time, the alarm bytes and the three enable bits as plain inputs. The update-done and periodic events arrive as one-cycle pulses.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset, `stat_o` is 0x00 and `irq_o` is 0.
- R2: An alarm byte with bits 7:6 equal to 2'b11 matches any value of its time field, independently for seconds, minutes and hours.
- R3: An alarm byte that is not a wildcard matches only when it equals the time byte in all 8 bits (seconds and minutes).
- R4: For hours in 12-hour mode (`mode_24h_i`=0), bit 7 is the PM flag and takes part in the compare. In 24-hour mode, bit 7 of both hour bytes is excluded from the compare.
- R5: The alarm flag (`stat_o` bit 5) is set on the cycle after an `upd_done_i` pulse during which all three fields match. A match with no update pulse sets nothing.
- R6: The update flag (`stat_o` bit 4) is set after each `upd_done_i` pulse. The periodic flag (`stat_o` bit 6) is set after each `per_tick_i` pulse. Both are set whatever the enable bits are.
- R7: The layout of `stat_o` is: bit 7 summary, bit 6 periodic, bit 5 alarm, bit 4 update. Bits 3:0 always read 0.
- R8: The summary bit (`stat_o` bit 7) and `irq_o` are both 1 exactly when a flag is set together with its enable (`per_en_i`, `alm_en_i`, `upd_en_i`). Raising an enable while its flag is already set raises the request at once.
- R9: A `stat_rd_i` pulse clears all flags, starting the next cycle.
- R10: An event that arrives in the same cycle as `stat_rd_i` is set after the read rather than lost.
- R11: A set flag, and an enabled request, stay set until the next `stat_rd_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_i | input | 8 | Current seconds |
| min_i | input | 8 | Current minutes |
| hour_i | input | 8 | Current hours, bit 7 is PM in 12-hour mode |
| alm_sec_i | input | 8 | Seconds alarm byte |
| alm_min_i | input | 8 | Minutes alarm byte |
| alm_hour_i | input | 8 | Hours alarm byte |
| mode_24h_i | input | 1 | 1 selects 24-hour mode |
| upd_done_i | input | 1 | One-cycle pulse at the end of a time update |
| per_tick_i | input | 1 | One-cycle periodic event pulse |
| per_en_i | input | 1 | Periodic interrupt enable |
| alm_en_i | input | 1 | Alarm interrupt enable |
| upd_en_i | input | 1 | Update interrupt enable |
| stat_rd_i | input | 1 | Status read strobe, clears the flags |
| stat_o | output | 8 | Interrupt status byte |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench puts the wildcard on one field at a time. A design that checked only the top bit, or applied the wildcard to the wrong field, would miss or invent an alarm. It sets a PM hour against an AM alarm in both hour modes. Dropping bit 7 in 12-hour mode would give a false alarm, and keeping it in 24-hour mode would lose a real one.

The bench holds an exact match with no update pulse, which catches an alarm flag that follows the compare level instead of the update pulse. It sets flags with their enables low, then raises the enables, to show that the summary bit follows the enables and not the events alone. It fires a periodic tick in the same cycle as a read, where a design that lets the clear win would drop the event.

// File: rtl/rtc_alm_pkg.sv
package rtc_alm_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned NUM_FIELDS = 3;
  localparam int unsigned NUM_EVT    = 3;

  typedef enum logic [1:0] {
    FLD_SEC  = 2'd0,
    FLD_MIN  = 2'd1,
    FLD_HOUR = 2'd2
  } field_e;

  // event index inside the flag vector; bit position in status = index + 4
  localparam int unsigned EVT_UPD = 0;
  localparam int unsigned EVT_ALM = 1;
  localparam int unsigned EVT_PER = 2;
  localparam int unsigned STAT_EVT_LSB = 4;

  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/rtc_alm_field_cmp.sv
module rtc_alm_field_cmp
  import rtc_alm_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] alm_i,
  input  logic [W-1:0] mask_i,
  output logic         hit_o
);
  localparam int unsigned DC_W = 2;

  logic wild;
  logic eq;

  assign wild  = &alm_i[W-1 -: DC_W];
  assign eq    = ((cur_i ^ alm_i) & mask_i) == '0;
  assign hit_o = wild | eq;
endmodule

// File: rtl/rtc_alm_match.sv
module rtc_alm_match
  import rtc_alm_pkg::*;
#(
  parameter int unsigned W = BYTE_W,
  parameter int unsigned N = NUM_FIELDS
) (
  input  logic [N-1:0][W-1:0] cur_i,
  input  logic [N-1:0][W-1:0] alm_i,
  input  logic                mode_24h_i,
  output logic                match_o
);
  localparam logic [W-1:0] FULL_MASK = '1;
  localparam logic [W-1:0] H24_MASK  = FULL_MASK >> 1;

  logic [N-1:0] hit;

  for (genvar g = 0; g < N; g++) begin : g_fld
    logic [W-1:0] mask;
    if (g == int'(FLD_HOUR)) begin : g_hour
      // in 24h mode bit 7 has no PM meaning
      assign mask = mode_24h_i ? H24_MASK : FULL_MASK;
    end else begin : g_plain
      assign mask = FULL_MASK;
    end
    rtc_alm_field_cmp #(.W(W)) u_cmp (
      .cur_i (cur_i[g]),
      .alm_i (alm_i[g]),
      .mask_i(mask),
      .hit_o (hit[g])
    );
  end

  assign match_o = &hit;
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
  import rtc_alm_pkg::*;
#(
  parameter int unsigned NE = NUM_EVT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NE-1:0] evt_i,
  input  logic [NE-1:0] en_i,
  input  logic          rd_i,
  output logic [NE-1:0] flag_o,
  output logic          irq_o
);
  logic [NE-1:0] flag_q;
  logic [NE-1:0] flag_d;

  // new events win over the clearing read
  assign flag_d = (rd_i ? '0 : flag_q) | evt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;
  assign irq_o  = |(flag_q & en_i);

  p_rd_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && (evt_i == '0) |=> (flag_o == '0));

  p_evt_kept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && (evt_i != '0) |=> ((flag_o & $past(evt_i)) == $past(evt_i)));

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> ((flag_o & $past(flag_o)) == $past(flag_o)));
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_alm_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sec_i,
  input  logic [W-1:0] min_i,
  input  logic [W-1:0] hour_i,
  input  logic [W-1:0] alm_sec_i,
  input  logic [W-1:0] alm_min_i,
  input  logic [W-1:0] alm_hour_i,
  input  logic         mode_24h_i,
  input  logic         upd_done_i,
  input  logic         per_tick_i,
  input  logic         per_en_i,
  input  logic         alm_en_i,
  input  logic         upd_en_i,
  input  logic         stat_rd_i,
  output logic [W-1:0] stat_o,
  output logic         irq_o
);
  localparam int unsigned N = NUM_FIELDS;

  logic [N-1:0][W-1:0] cur;
  logic [N-1:0][W-1:0] alm;
  logic                match;
  logic [NUM_EVT-1:0]  evt;
  logic [NUM_EVT-1:0]  en;
  logic [NUM_EVT-1:0]  flag;
  logic                irq;

  assign cur[FLD_SEC]  = sec_i;
  assign cur[FLD_MIN]  = min_i;
  assign cur[FLD_HOUR] = hour_i;
  assign alm[FLD_SEC]  = alm_sec_i;
  assign alm[FLD_MIN]  = alm_min_i;
  assign alm[FLD_HOUR] = alm_hour_i;

  rtc_alm_match #(.W(W), .N(N)) u_match (
    .cur_i     (cur),
    .alm_i     (alm),
    .mode_24h_i(mode_24h_i),
    .match_o   (match)
  );

  always_comb begin
    evt          = '0;
    evt[EVT_UPD] = upd_done_i;
    evt[EVT_ALM] = upd_done_i & match;  // compare sampled only on update
    evt[EVT_PER] = per_tick_i;
    en           = '0;
    en[EVT_UPD]  = upd_en_i;
    en[EVT_ALM]  = alm_en_i;
    en[EVT_PER]  = per_en_i;
  end

  rtc_irq_flags #(.NE(NUM_EVT)) u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (evt),
    .en_i  (en),
    .rd_i  (stat_rd_i),
    .flag_o(flag),
    .irq_o (irq)
  );

  always_comb begin
    stat_o = '0;
    stat_o[STAT_EVT_LSB +: NUM_EVT] = flag;
    stat_o[W-1] = irq;
  end

  assign irq_o = irq;

  p_alm_on_upd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_o[5]) |-> $past(upd_done_i && match));

  p_upd_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_done_i |=> stat_o[4]);

  p_irq_level_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o[6] && per_en_i) |-> irq_o);

  p_low_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[3:0] == 4'h0);
endmodule

// File: tb/tb_rtc_alarm_irq.sv
`timescale 1ns/1ps
module tb_rtc_alarm_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sec, mins, hour, a_sec, a_min, a_hour;
  logic       m24, upd, per, pen, aen, uen, rd;
  logic [7:0] stat;
  logic       irq;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_alarm_irq dut (
    .clk_i(clk), .rst_ni(rst_n),
    .sec_i(sec), .min_i(mins), .hour_i(hour),
    .alm_sec_i(a_sec), .alm_min_i(a_min), .alm_hour_i(a_hour),
    .mode_24h_i(m24), .upd_done_i(upd), .per_tick_i(per),
    .per_en_i(pen), .alm_en_i(aen), .upd_en_i(uen),
    .stat_rd_i(rd), .stat_o(stat), .irq_o(irq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cyc(); @(posedge clk); @(negedge clk); endtask
  task automatic pulse_upd(); upd = 1'b1; cyc(); upd = 1'b0; endtask
  task automatic pulse_per(); per = 1'b1; cyc(); per = 1'b0; endtask
  task automatic do_read(); rd = 1'b1; cyc(); rd = 1'b0; endtask

  task automatic set_time(logic [7:0] s, logic [7:0] m, logic [7:0] h);
    sec = s; mins = m; hour = h;
  endtask
  task automatic set_alm(logic [7:0] s, logic [7:0] m, logic [7:0] h);
    a_sec = s; a_min = m; a_hour = h;
  endtask

  task automatic t_reset();
    chk("R1 stat", stat, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_wildcard();
    m24 = 1'b1;
    set_time(8'h12, 8'h34, 8'h05);
    set_alm(8'hC0, 8'hC0, 8'hC0);
    pulse_upd();
    chk("R2 all wild R6 R7", stat, 8'h30);
    do_read();
    chk("R9 clear", stat, 8'h00);
    set_alm(8'hC7, 8'h34, 8'h05);
    pulse_upd();
    chk("R2 sec wild", stat, 8'h30);
    do_read();
    set_alm(8'h12, 8'h34, 8'hFF);
    pulse_upd();
    chk("R2 hour wild", stat, 8'h30);
    do_read();
    set_alm(8'h80, 8'h34, 8'h05);
    pulse_upd();
    chk("R2 single top bit not wild", stat, 8'h10);
    do_read();
  endtask

  task automatic t_exact();
    set_alm(8'h12, 8'h34, 8'h05);
    pulse_upd();
    chk("R3 exact match", stat, 8'h30);
    do_read();
    set_alm(8'h13, 8'h34, 8'h05);
    pulse_upd();
    chk("R3 sec mismatch", stat, 8'h10);
    do_read();
    set_alm(8'h12, 8'h35, 8'h05);
    pulse_upd();
    chk("R3 min mismatch", stat, 8'h10);
    do_read();
  endtask

  task automatic t_no_strobe();
    set_alm(8'h12, 8'h34, 8'h05);
    repeat (4) cyc();
    chk("R5 match without update", stat, 8'h00);
  endtask

  task automatic t_hours();
    set_time(8'h12, 8'h34, 8'h85);
    set_alm(8'h12, 8'h34, 8'h05);
    m24 = 1'b0;
    pulse_upd();
    chk("R4 12h pm vs am", stat, 8'h10);
    do_read();
    set_alm(8'h12, 8'h34, 8'h85);
    pulse_upd();
    chk("R4 12h pm match", stat, 8'h30);
    do_read();
    m24 = 1'b1;
    set_alm(8'h12, 8'h34, 8'h05);
    pulse_upd();
    chk("R4 24h bit7 ignored", stat, 8'h30);
    do_read();
  endtask

  task automatic t_irq();
    pulse_per();
    chk("R6 per flag no enable", stat, 8'h40);
    chk("R8 irq off", {7'd0, irq}, 8'h00);
    uen = 1'b1; aen = 1'b1;
    #1;
    chk("R8 other enables", stat, 8'h40);
    pen = 1'b1;
    #1;
    chk("R8 late enable stat", stat, 8'hC0);
    chk("R8 late enable irq", {7'd0, irq}, 8'h01);
    repeat (5) cyc();
    chk("R11 hold", {stat[7:1], irq}, 8'hC1);
    do_read();
    chk("R9 read clears irq", {stat[7:1], irq}, 8'h00);
    set_alm(8'h00, 8'h34, 8'h05);
    uen = 1'b0; pen = 1'b0;
    pulse_upd();
    chk("R8 update only no irq", {stat[7:1], irq}, 8'h10);
    do_read();
    set_alm(8'h12, 8'h34, 8'h05);
    pulse_upd();
    chk("R8 alarm irq", {stat[7:1], irq}, 8'hB1);
    do_read();
    aen = 1'b0;
  endtask

  task automatic t_collision();
    pulse_upd();
    rd = 1'b1; per = 1'b1;
    cyc();
    rd = 1'b0; per = 1'b0;
    chk("R10 event kept on read", stat, 8'h40);
    do_read();
    chk("R9 final clear", stat, 8'h00);
  endtask

  initial begin
    set_time(0, 0, 0); set_alm(0, 0, 0);
    m24 = 0; upd = 0; per = 0; pen = 0; aen = 0; uen = 0; rd = 0;
    #1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_wildcard();
    t_exact();
    t_no_strobe();
    t_hours();
    t_irq();
    t_collision();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule